// File: doc/BRIEF.md
# Global Set/Reset Distribution Controller

The controller drives the chip-wide set/reset strobe that initializes every user flip-flop and latch. After power-up the strobe is asserted and held through configuration. It lets go only when the start-up sequencer signals release after configuration has ended. The release timing is chosen outside this block. Once released, an option field selects what can drive the strobe again: nothing, the external reset pad, or an internally routed signal. A second option bit sets the strobe's polarity on the net. By default the net is active-low.

The reset pad has two roles. While configuration is active, asserting the pad (driving it low) produces a one-cycle abort request for the configuration controller. After configuration it can act as a strobe source. When pad assertion acts as a source, it reaches the strobe at once. Its release passes through a two-stage synchronizer on the user clock. When the pad is not the selected source, its level is forwarded as an ordinary user input.

A bank of model storage elements shows how the strobe acts on user registers. Each element has its own bit that chooses whether the strobe sets it or clears it. When the strobe is not asserted, the element loads user data.

Top module: `gsr_ctrl`

## Requirements
- R1: While `rst_ni` is low (power-on), the strobe is asserted, `abort_o` is 0 and the pad synchronizer holds the asserted state.
- R2: At any clock edge where `cfg_active_i` is 1, the strobe becomes (and then stays) asserted, even if `release_i` is 1.
- R3: The strobe, with no other source active, deasserts after the first clock edge at which `release_i` is 1 and `cfg_active_i` is 0, and stays deasserted until a source re-asserts it.
- R4: After release, with `src_sel_i` = 0 (off) or 3 (reserved, treated as off), neither the pad nor `routed_rst_i` has any effect on the strobe.
- R5: After release, with `src_sel_i` = 1 (pad), a low on `pad_rst_ni` asserts the strobe without waiting for a clock edge. After the pad returns high, the strobe deasserts following the second rising edge of `clk_i`.
- R6: After release, with `src_sel_i` = 2 (routed), `routed_rst_i` = 1 asserts the strobe combinationally.
- R7: With `invert_i` = 0 the strobe is active-low on `gsr_o` (asserted means `gsr_o` = 0). With `invert_i` = 1 it is active-high.
- R8: A falling edge of the synchronized pad while `cfg_active_i` is 1 raises `abort_o` for exactly one cycle, beginning at the first rising edge after the pad falls. Outside configuration, `abort_o` stays 0.
- R9: `pad_user_o` equals `pad_rst_ni` whenever `src_sel_i` is not 1, and is held at 1 when `src_sel_i` is 1.
- R10: At each clock edge with the strobe asserted, `reg_q_o[i]` takes `init_val_i[i]` (1 = set, 0 = clear). Otherwise it takes `user_d_i[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | User clock |
| rst_ni | input | 1 | Power-on indication, active low |
| cfg_active_i | input | 1 | Configuration in progress |
| release_i | input | 1 | Release request from the start-up sequencer |
| pad_rst_ni | input | 1 | External reset pad, active low |
| routed_rst_i | input | 1 | Internal routed reset, active high |
| src_sel_i | input | 2 | Post-configuration source: 0 off, 1 pad, 2 routed, 3 off |
| invert_i | input | 1 | Strobe polarity: 0 active-low, 1 active-high |
| init_val_i | input | N_REGS | Per-element set (1) or clear (0) select |
| user_d_i | input | N_REGS | User data for the model elements |
| gsr_o | output | 1 | Global set/reset strobe on the net |
| abort_o | output | 1 | Configuration-abort request pulse |
| pad_user_o | output | 1 | Pad value forwarded as a user input |
| reg_q_o | output | N_REGS | Model storage element outputs |

## Verification
On every cycle, the assertions check these rules: the strobe is held during power-on and configuration, the routed source forces the strobe, the pad is forwarded when it is not the selected source, the abort pulse lasts one cycle and appears only during configuration, and the model elements load their init values after an asserted edge. The bench scenarios show the timing-dependent behaviour. This covers the immediate pad assertion and the two-edge release, the release taking effect only after configuration ends, polarity changes applied live, and the abort appearing exactly one edge after a pad fall. The bench checks these against a cycle model across random changes of source, polarity and configuration state.

// File: rtl/gsr_pkg.sv
package gsr_pkg;
  typedef enum logic [1:0] {
    GSR_SRC_OFF    = 2'd0,
    GSR_SRC_PAD    = 2'd1,
    GSR_SRC_ROUTED = 2'd2,
    GSR_SRC_RSVD   = 2'd3
  } gsr_src_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/gsr_pad_sync.sv
module gsr_pad_sync
  import gsr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pad_ni,
  input  logic cfg_active_i,
  output logic pad_sync_no,
  output logic abort_o
);
  logic                   arst_n;
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;
  logic                   abort_q;

  assign arst_n = rst_ni & pad_ni;

  // assert asynchronously, release through the chain
  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign pad_sync_no = chain_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      prev_q  <= pad_sync_no;
      abort_q <= cfg_active_i & prev_q & ~pad_sync_no;
    end
  end

  assign abort_o = abort_q;
endmodule

// File: rtl/gsr_init_bank.sv
module gsr_init_bank #(
  parameter int unsigned N_REGS = 8
) (
  input  logic              clk_i,
  input  logic              load_init_i,
  input  logic [N_REGS-1:0] init_val_i,
  input  logic [N_REGS-1:0] user_d_i,
  output logic [N_REGS-1:0] reg_q_o
);
  for (genvar i = 0; i < N_REGS; i++) begin : g_cell
    logic q;
    always_ff @(posedge clk_i) begin
      if (load_init_i) q <= init_val_i[i];
      else             q <= user_d_i[i];
    end
    assign reg_q_o[i] = q;
  end
endmodule

// File: rtl/gsr_ctrl.sv
module gsr_ctrl
  import gsr_pkg::*;
#(
  parameter int unsigned N_REGS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_active_i,
  input  logic              release_i,
  input  logic              pad_rst_ni,
  input  logic              routed_rst_i,
  input  logic [1:0]        src_sel_i,
  input  logic              invert_i,
  input  logic [N_REGS-1:0] init_val_i,
  input  logic [N_REGS-1:0] user_d_i,
  output logic              gsr_o,
  output logic              abort_o,
  output logic              pad_user_o,
  output logic [N_REGS-1:0] reg_q_o
);
  gsr_src_e src;
  logic     released_q;
  logic     pad_sync_n;
  logic     gsr_act;

  assign src = gsr_src_e'(src_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           released_q <= 1'b0;
    else if (cfg_active_i) released_q <= 1'b0;
    else if (release_i)    released_q <= 1'b1;
  end

  gsr_pad_sync u_pad_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pad_ni      (pad_rst_ni),
    .cfg_active_i(cfg_active_i),
    .pad_sync_no (pad_sync_n),
    .abort_o     (abort_o)
  );

  always_comb begin
    gsr_act = ~released_q;
    unique case (src)
      GSR_SRC_PAD:    gsr_act = gsr_act | ~pad_sync_n;
      GSR_SRC_ROUTED: gsr_act = gsr_act | routed_rst_i;
      default:        ;
    endcase
  end

  assign gsr_o      = invert_i ? gsr_act : ~gsr_act;
  assign pad_user_o = (src == GSR_SRC_PAD) ? 1'b1 : pad_rst_ni;

  gsr_init_bank #(.N_REGS(N_REGS)) u_bank (
    .clk_i      (clk_i),
    .load_init_i(gsr_act),
    .init_val_i (init_val_i),
    .user_d_i   (user_d_i),
    .reg_q_o    (reg_q_o)
  );
endmodule

// File: rtl/gsr_ctrl_chk.sv
module gsr_ctrl_chk #(
  parameter int unsigned N_REGS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_active_i,
  input logic              pad_rst_ni,
  input logic              routed_rst_i,
  input logic [1:0]        src_sel_i,
  input logic              invert_i,
  input logic [N_REGS-1:0] init_val_i,
  input logic              gsr_o,
  input logic              abort_o,
  input logic              pad_user_o,
  input logic [N_REGS-1:0] reg_q_o
);
  logic asserted;
  assign asserted = (gsr_o == invert_i);

  assert_poweron_hold_R1: assert property (@(posedge clk_i)
    !rst_ni |-> asserted && !abort_o);

  assert_cfg_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_active_i) |-> asserted);

  assert_routed_force_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == 2'd2 && routed_rst_i) |-> asserted);

  assert_abort_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);

  assert_abort_in_cfg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(cfg_active_i));

  assert_pad_forward_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i != 2'd1) |-> (pad_user_o == pad_rst_ni));

  assert_init_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(asserted) |-> (reg_q_o == $past(init_val_i)));
endmodule

bind gsr_ctrl gsr_ctrl_chk #(.N_REGS(N_REGS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_active_i(cfg_active_i),
  .pad_rst_ni  (pad_rst_ni),
  .routed_rst_i(routed_rst_i),
  .src_sel_i   (src_sel_i),
  .invert_i    (invert_i),
  .init_val_i  (init_val_i),
  .gsr_o       (gsr_o),
  .abort_o     (abort_o),
  .pad_user_o  (pad_user_o),
  .reg_q_o     (reg_q_o)
);

// File: tb/tb_gsr_ctrl.sv
`timescale 1ns/1ps
module tb_gsr_ctrl;
  localparam int unsigned N = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni, cfg_active_i, release_i, pad_rst_ni, routed_rst_i, invert_i;
  logic [1:0]   src_sel_i;
  logic [N-1:0] init_val_i, user_d_i;
  logic         gsr_o, abort_o, pad_user_o;
  logic [N-1:0] reg_q_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // cycle model state
  bit           m_rel, m_prev, m_abort;
  int           m_cnt;
  logic [N-1:0] m_q;

  always #5 clk_i = ~clk_i;

  gsr_ctrl #(.N_REGS(N)) dut (.*);

  function automatic void apply_async();
    if (!rst_ni) begin m_rel = 0; m_prev = 0; m_abort = 0; m_cnt = 0; end
    if (!pad_rst_ni) m_cnt = 0;
  endfunction

  function automatic bit m_sync();
    return pad_rst_ni && m_cnt >= 2;
  endfunction

  function automatic bit m_act();
    bit a;
    a = !m_rel;
    if (src_sel_i == 2'd1 && !m_sync()) a = 1;
    if (src_sel_i == 2'd2 && routed_rst_i) a = 1;
    return a;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_comb();
    bit a, e;
    string tag;
    apply_async();
    a = m_act();
    e = invert_i ? a : !a;
    if (!rst_ni) tag = "R1";
    else if (!m_rel) tag = "R2/R3/R7";
    else if (src_sel_i == 2'd1) tag = "R5/R7";
    else if (src_sel_i == 2'd2) tag = "R6/R7";
    else tag = "R4/R7";
    chk(gsr_o === e, tag, N'(gsr_o), N'(e));
    e = (src_sel_i == 2'd1) ? 1'b1 : pad_rst_ni;
    chk(pad_user_o === e, "R9", N'(pad_user_o), N'(e));
  endtask

  task automatic model_edge();
    bit a, s;
    apply_async();
    a = m_act();
    s = m_sync();
    if (rst_ni) begin
      m_abort = cfg_active_i && m_prev && !s;
      m_prev  = s;
      if (pad_rst_ni && m_cnt < 2) m_cnt++;
      if (cfg_active_i) m_rel = 0;
      else if (release_i) m_rel = 1;
    end
    m_q = a ? init_val_i : user_d_i;
  endtask

  task automatic cycle();
    #1 check_comb();
    @(posedge clk_i);
    model_edge();
    #1;
    chk(abort_o === m_abort, rst_ni ? "R8" : "R1", N'(abort_o), N'(m_abort));
    chk(reg_q_o === m_q, "R10", reg_q_o, m_q);
    @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_ni = 0; cfg_active_i = 1; release_i = 0; pad_rst_ni = 1; routed_rst_i = 0;
    src_sel_i = 2'd0; invert_i = 0; init_val_i = 8'hA5; user_d_i = 8'h3C;
    m_q = '0;
    @(negedge clk_i);
    // R1: power-on hold
    repeat (3) cycle();
    rst_ni = 1;
    // R2: held through configuration even with release requested
    release_i = 1;
    repeat (4) cycle();
    // R8: pad pulse during configuration -> one abort pulse
    pad_rst_ni = 0; cycle(); cycle(); pad_rst_ni = 1;
    repeat (4) cycle();
    // R3: release after configuration
    cfg_active_i = 0; release_i = 0; cycle(); cycle();
    release_i = 1; cycle(); release_i = 0;
    repeat (3) cycle();
    // R5: pad source, async assert and two-edge release
    src_sel_i = 2'd1; pad_rst_ni = 0; cycle(); pad_rst_ni = 1;
    repeat (4) cycle();
    // R7: inverted polarity with routed source
    invert_i = 1; src_sel_i = 2'd2; routed_rst_i = 1; cycle(); routed_rst_i = 0; cycle();
    // R4: reserved code behaves as off
    src_sel_i = 2'd3; pad_rst_ni = 0; routed_rst_i = 1; cycle(); pad_rst_ni = 1; routed_rst_i = 0; cycle();
    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) pad_rst_ni = ~pad_rst_ni;
      if ($urandom_range(5) == 0) routed_rst_i = ~routed_rst_i;
      if ($urandom_range(31) == 0) src_sel_i = 2'($urandom_range(3));
      if ($urandom_range(15) == 0) invert_i = ~invert_i;
      if ($urandom_range(63) == 0) cfg_active_i = ~cfg_active_i;
      release_i = ($urandom_range(3) == 0);
      init_val_i = N'($urandom);
      user_d_i = N'($urandom);
      if (i == 2000) begin rst_ni = 0; cycle(); rst_ni = 1; end
      cycle();
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule